// File: doc/BRIEF.md
# Half-Duplex Asynchronous Serial Transceiver

This block is a single-channel asynchronous serial port that either sends or receives, never both at once. A direction input chooses which engine is live. The idle engine is held at rest. Bit timing comes from an internal divider that turns the system clock into a tick at sixteen times the bit rate, so the block has no clock pin of its own. The data width (five to eight bits), the parity (off, odd or even), the number of stop bits and the line polarity are plain configuration inputs. Software changes them only while the engine is idle.

On the transmit side, a one-cycle write strobe loads a byte and sends the whole frame. On the receive side, the block hunts for a start level and confirms it half a bit later. It then samples every later bit at its centre and delivers the data with parity, framing and overrun flags. A read strobe acknowledges the data. When a frame completes in either direction, the block emits a single maskable interrupt pulse.

Top module: `hdx_uart`

## Requirements
- R1: After a clock edge with `rst_n` low, `txd` is at the idle mark level, which is 1 when `line_inv` is 0. `tx_busy`, `rx_valid`, `par_err`, `frm_err`, `ovr_err` and `irq` are 0, and `rx_data` is 0.
- R2: Every bit on the line lasts exactly 16*(`baud_div`+1) clock cycles. A transmit frame's start bit appears on `txd` right after the clock edge that accepts `tx_wr`.
- R3: A transmitted frame is sent in this order: a start bit at level 0, then the data bits least significant first, then the parity bit if parity is on, then the stop bits at level 1. The number of data bits is 5 + `len_sel` (`len_sel` 0..3 gives 5..8 bits). The unused upper bits of `tx_data` are not sent.
- R4: `par_sel` selects the parity: 2'b01 is odd, 2'b10 is even, and 2'b00 or 2'b11 means no parity bit. Parity covers only the selected data bits. With odd parity, the data bits plus the parity bit hold an odd number of ones. With even parity, they hold an even number.
- R5: `stop_two`=1 sends two stop bits and `stop_two`=0 sends one. The receiver checks only the first stop bit in either case.
- R6: With `line_inv`=1, the level on `txd` is the inverse of the logical level in R3, including idle. The level on `rxd` is also read inverted.
- R7: The transmitter works only while `dir_tx`=1 and the receiver only while `dir_tx`=0. `tx_wr` has no effect while `dir_tx`=0 or while `tx_busy`=1. Activity on `rxd` while `dir_tx`=1 never produces received data.
- R8: A start level on `rxd` that has returned to idle by the centre of the start bit is dropped. It leaves no trace on any output.
- R9: After a received frame, `rx_data` (data right-aligned, upper bits 0), the error flags and `rx_valid` update 2+(8+16n)*(`baud_div`+1) cycles after the first clock edge that samples the start level on `rxd`. Here n is the number of data bits plus the parity bit (if on) plus one.
- R10: A first stop bit sampled at 0 sets `frm_err`, and a received parity bit that disagrees with R4 sets `par_err`. The data is delivered anyway. Both flags are rewritten by every received frame.
- R11: If a frame completes while `rx_valid` is still 1 and `rx_rd` is not asserted in that cycle, `ovr_err` is set and the new data replaces the old. A cycle with `rx_rd`=1 and no frame completing clears both `rx_valid` and `ovr_err`.
- R12: With `irq_en`=1, `irq` pulses high for one cycle when each frame completes. For a transmit frame, that is the cycle `tx_busy` falls. For a receive frame, it is the cycle the results of R9 appear. With `irq_en`=0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_div | input | 16 | Oversampling divider; one tick every baud_div+1 cycles |
| dir_tx | input | 1 | 1 selects transmit, 0 selects receive |
| line_inv | input | 1 | 1 inverts both line signals |
| len_sel | input | 2 | Data bits = 5 + len_sel |
| par_sel | input | 2 | 01 odd, 10 even, otherwise no parity |
| stop_two | input | 1 | 1 sends two stop bits |
| irq_en | input | 1 | Interrupt mask, 1 enables |
| tx_wr | input | 1 | Write strobe that starts a transmit frame |
| tx_data | input | 8 | Data to transmit |
| rx_rd | input | 1 | Read strobe that acknowledges received data |
| rxd | input | 1 | Serial line in |
| txd | output | 1 | Serial line out |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_data | output | 8 | Last received data |
| rx_valid | output | 1 | Unread received data present |
| par_err | output | 1 | Parity mismatch in the last frame |
| frm_err | output | 1 | Bad stop bit in the last frame |
| ovr_err | output | 1 | Received data was overwritten before being read |
| irq | output | 1 | One-cycle frame-complete pulse |

## Verification
A divider or sub-bit counter that slips by even one cycle moves the next edge on `txd` away from its 16*(`baud_div`+1) slot. Because the line is compared every cycle, the fault shows within one bit time. A receiver whose sample point drifts, or whose bit index is wrong, gives the wrong `rx_data`, `par_err` or `frm_err`. That error is caught on the exact cycle R9 names, or through `rx_valid` rising a cycle too early or too late. A stuck state in the start qualifier, or a leak between the two directions, gives an unexpected `rx_valid` or `tx_busy` within one frame.

// File: rtl/hdx_uart_pkg.sv
// Shared constants and helpers for the half-duplex serial transceiver.
// Assumes at most 8 data bits and a 2-bit width code.
package hdx_uart_pkg;
    localparam int UART_DMAX = 8;   // widest data field
    localparam int UART_SMAX = 2;   // most stop bits

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

    // Number of data bits selected by the width code.
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // True when a parity bit is part of the frame.
    function automatic logic par_on(input logic [1:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN);
    endfunction

    // Parity bit value for already-masked data.
    function automatic logic par_bit(input logic [UART_DMAX-1:0] d, input logic [1:0] mode);
        return (mode == PAR_ODD) ? ~^d : ^d;
    endfunction
endpackage

// File: rtl/hdx_uart_baud.sv
// Oversampling tick source. It emits one tick every div+1 cycles while
// run is high, and counts ticks modulo 16 in sub. A restart puts both
// counters back to zero, so bit timing lines up with the caller's event.
// Assumes div is stable while run is high.
module hdx_uart_baud #(
    parameter int DIV_W = 16,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic [SUB_W-1:0] sub
);
    logic [DIV_W-1:0] pcnt;
    logic [SUB_W-1:0] scnt;

    // Prescaler and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (restart) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (run) begin
            if (pcnt == div) begin
                pcnt <= '0;
                scnt <= scnt + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // Tick decode.
    always_comb begin
        tick = run && (pcnt == div);
        sub  = scnt;
    end
endmodule

// File: rtl/hdx_uart_tx.sv
// Transmit engine. It builds the whole frame (start, data LSB first,
// optional parity, stop bits) in one shift register when the write is
// accepted, then shifts one bit out every 16 ticks. The output is the
// logical line level, and the top applies polarity.
// Assumes configuration is stable while busy.
module hdx_uart_tx
    import hdx_uart_pkg::*;
#(
    parameter int DW    = UART_DMAX,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr,
    input  logic [DW-1:0]    din,
    input  logic [1:0]       len_code,
    input  logic [1:0]       par_mode,
    input  logic             stop_two,
    input  logic             tick,
    input  logic [SUB_W-1:0] sub,
    output logic             restart,
    output logic             busy,
    output logic             fin,
    output logic             line
);
    localparam int FW = 1 + DW + 1 + UART_SMAX;
    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] sh;
    logic [CW-1:0] left;
    logic [FW-1:0] frame;
    logic [CW-1:0] nbits;
    logic [DW-1:0] dmask;
    logic [3:0]    len;
    logic          pen;
    logic          bit_end;

    // Frame image and length for the pending write.
    always_comb begin
        len   = data_bits(len_code);
        pen   = par_on(par_mode);
        dmask = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(len)) dmask[i] = din[i];
        end
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(len)) frame[i+1] = din[i];
        end
        for (int j = 1; j < FW; j++) begin
            if (pen && (j == int'(len) + 1)) frame[j] = par_bit(dmask, par_mode);
        end
        nbits = CW'(1) + CW'(len) + CW'(pen) + (stop_two ? CW'(2) : CW'(1));
    end

    // Bit boundary and completion decode.
    always_comb begin
        bit_end = busy && tick && (sub == {SUB_W{1'b1}});
        fin     = enable && bit_end && (left == CW'(1));
        restart = enable && !busy && wr;
        line    = busy ? sh[0] : 1'b1;
    end

    // Frame shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (!enable) begin
            busy <= 1'b0;
        end else if (!busy && wr) begin
            busy <= 1'b1;
            sh   <= frame;
            left <= nbits;
        end else if (bit_end) begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
            if (left == CW'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/hdx_uart_rx.sv
// Receive engine. It sees a start level and re-checks it at tick 8
// (mid-bit), then samples each later bit every 16 ticks at its centre.
// It ends at the first stop bit. It holds the result, the error flags and
// the valid/overrun state.
// Assumes lvl is already synchronised and polarity-corrected.
module hdx_uart_rx
    import hdx_uart_pkg::*;
#(
    parameter int DW    = UART_DMAX,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             lvl,
    input  logic [1:0]       len_code,
    input  logic [1:0]       par_mode,
    input  logic             tick,
    input  logic [SUB_W-1:0] sub,
    input  logic             rd,
    output logic             restart,
    output logic             run,
    output logic             fin,
    output logic [DW-1:0]    data_q,
    output logic             valid_q,
    output logic             perr_q,
    output logic             ferr_q,
    output logic             oerr_q
);
    localparam int RW = DW + 2;
    localparam int KW = $clog2(RW);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

    rx_state_e      st;
    logic [KW-1:0]  k;
    logic [RW-1:0]  rbits;
    logic [3:0]     len;
    logic           pen;
    logic           mid_pt;
    logic           bit_pt;
    logic           last;
    logic [DW-1:0]  dat;
    logic           perr_n;

    // Sample points and decoded result of the frame in flight.
    always_comb begin
        len    = data_bits(len_code);
        pen    = par_on(par_mode);
        mid_pt = tick && (sub == SUB_W'(7));
        bit_pt = tick && (sub == {SUB_W{1'b1}});
        last   = (int'(k) == int'(len) + int'(pen));
        dat    = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(len)) dat[i] = rbits[i];
        end
        perr_n  = pen && (rbits[len] != par_bit(dat, par_mode));
        fin     = enable && (st == RX_BITS) && bit_pt && last;
        restart = enable && !lvl &&
                  ((st == RX_IDLE) || ((st == RX_START) && mid_pt));
        run     = (st != RX_IDLE);
    end

    // Frame sequencer and sample store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            k     <= '0;
            rbits <= '0;
        end else if (!enable) begin
            st <= RX_IDLE;
        end else begin
            case (st)
                RX_IDLE:  if (!lvl) st <= RX_START;
                RX_START: if (mid_pt) begin
                    if (lvl) st <= RX_IDLE;
                    else begin
                        st <= RX_BITS;
                        k  <= '0;
                    end
                end
                RX_BITS:  if (bit_pt) begin
                    rbits[k] <= lvl;
                    if (last) st <= RX_IDLE;
                    else      k  <= k + 1'b1;
                end
                default:  st <= RX_IDLE;
            endcase
        end
    end

    // Result registers, valid and overrun bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            oerr_q  <= 1'b0;
        end else if (fin) begin
            data_q  <= dat;
            valid_q <= 1'b1;
            perr_q  <= perr_n;
            ferr_q  <= !lvl;
            oerr_q  <= (valid_q || oerr_q) && !rd;
        end else if (rd) begin
            valid_q <= 1'b0;
            oerr_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/hdx_uart.sv
// Half-duplex serial transceiver top. It selects the live direction,
// synchronises and polarity-corrects the incoming line, gives each
// engine its own tick source, and registers the frame-complete interrupt.
// Assumes the configuration inputs change only while both engines are idle.
module hdx_uart
    import hdx_uart_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DW          = UART_DMAX,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             dir_tx,
    input  logic             line_inv,
    input  logic [1:0]       len_sel,
    input  logic [1:0]       par_sel,
    input  logic             stop_two,
    input  logic             irq_en,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_data,
    input  logic             rx_rd,
    input  logic             rxd,
    output logic             txd,
    output logic             tx_busy,
    output logic [DW-1:0]    rx_data,
    output logic             rx_valid,
    output logic             par_err,
    output logic             frm_err,
    output logic             ovr_err,
    output logic             irq
);
    localparam int SUB_W = 4;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   tx_restart, tx_fin, tx_line, tx_tick;
    logic [SUB_W-1:0]       tx_sub;
    logic                   rx_restart, rx_run, rx_fin, rx_tick;
    logic [SUB_W-1:0]       rx_sub;
    logic                   irq_q;

    // Metastability guard on the incoming line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    // Line polarity on both directions.
    always_comb begin
        lvl = sync_q[SYNC_STAGES-1] ^ line_inv;
        txd = tx_line ^ line_inv;
    end

    hdx_uart_baud #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_tx_baud (
        .clk(clk), .rst_n(rst_n), .restart(tx_restart), .run(tx_busy),
        .div(baud_div), .tick(tx_tick), .sub(tx_sub)
    );

    hdx_uart_tx #(.DW(DW), .SUB_W(SUB_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(dir_tx), .wr(tx_wr), .din(tx_data),
        .len_code(len_sel), .par_mode(par_sel), .stop_two(stop_two),
        .tick(tx_tick), .sub(tx_sub), .restart(tx_restart), .busy(tx_busy),
        .fin(tx_fin), .line(tx_line)
    );

    hdx_uart_baud #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_rx_baud (
        .clk(clk), .rst_n(rst_n), .restart(rx_restart), .run(rx_run),
        .div(baud_div), .tick(rx_tick), .sub(rx_sub)
    );

    hdx_uart_rx #(.DW(DW), .SUB_W(SUB_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(!dir_tx), .lvl(lvl),
        .len_code(len_sel), .par_mode(par_sel), .tick(rx_tick), .sub(rx_sub),
        .rd(rx_rd), .restart(rx_restart), .run(rx_run), .fin(rx_fin),
        .data_q(rx_data), .valid_q(rx_valid), .perr_q(par_err),
        .ferr_q(frm_err), .oerr_q(ovr_err)
    );

    // Maskable frame-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_en && (tx_fin || rx_fin);
    end

    assign irq = irq_q;
endmodule

// File: rtl/hdx_uart_checker.sv
// Port-level properties of the half-duplex transceiver, bound to the top.
module hdx_uart_checker (
    input logic clk,
    input logic rst_n,
    input logic dir_tx,
    input logic line_inv,
    input logic irq_en,
    input logic tx_wr,
    input logic rx_rd,
    input logic txd,
    input logic tx_busy,
    input logic rx_valid,
    input logic ovr_err,
    input logic irq
);
    // R7: transmitter idles whenever receive is selected
    p_tx_held_in_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx |=> !tx_busy);

    // R7: a frame starts only from a write in transmit mode
    p_busy_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> ($past(tx_wr) && $past(dir_tx)));

    // R7: no received data appears while transmit is selected
    p_rx_quiet_in_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |=> !$rose(rx_valid));

    // R6: first bit of a frame is the start level, inverted with the line
    p_start_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (txd == line_inv));

    // R12: interrupt is a single-cycle pulse
    p_irq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12: masked interrupt never fires
    p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    // R11: overrun only when unread data was already held
    p_ovr_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $past(rx_valid));

    // R11: valid drops only on a read
    p_valid_drop_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_valid) |-> $past(rx_rd));
endmodule

bind hdx_uart hdx_uart_checker u_chk (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .line_inv(line_inv),
    .irq_en(irq_en), .tx_wr(tx_wr), .rx_rd(rx_rd), .txd(txd),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .ovr_err(ovr_err), .irq(irq)
);

// File: tb/hdx_uart_test.sv
// Bench for the half-duplex transceiver. A behavioural model updates the
// expected port values cycle by cycle, and every port is compared on every clock.
module hdx_uart_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic        dir_tx = 1'b1;
    logic        line_inv = 1'b0;
    logic [1:0]  len_sel = 2'd3;
    logic [1:0]  par_sel = 2'd0;
    logic        stop_two = 1'b0;
    logic        irq_en = 1'b1;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        rx_rd = 1'b0;
    logic        rxd = 1'b1;
    logic        txd, tx_busy, rx_valid, par_err, frm_err, ovr_err, irq;
    logic [7:0]  rx_data;

    // Expected port values.
    logic       exp_txd = 1'b1, exp_busy = 1'b0, exp_valid = 1'b0;
    logic       exp_perr = 1'b0, exp_ferr = 1'b0, exp_ovr = 1'b0, exp_irq = 1'b0;
    logic [7:0] exp_data = 8'h00;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    hdx_uart uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .dir_tx(dir_tx),
        .line_inv(line_inv), .len_sel(len_sel), .par_sel(par_sel),
        .stop_two(stop_two), .irq_en(irq_en), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rxd(rxd), .txd(txd), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .irq(irq)
    );

    task automatic cmp(input string name, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    // Compare all outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            cmp("txd", {7'd0, txd}, {7'd0, exp_txd});
            cmp("tx_busy", {7'd0, tx_busy}, {7'd0, exp_busy});
            cmp("rx_valid", {7'd0, rx_valid}, {7'd0, exp_valid});
            cmp("rx_data", rx_data, exp_data);
            cmp("par_err", {7'd0, par_err}, {7'd0, exp_perr});
            cmp("frm_err", {7'd0, frm_err}, {7'd0, exp_ferr});
            cmp("ovr_err", {7'd0, ovr_err}, {7'd0, exp_ovr});
            cmp("irq", {7'd0, irq}, {7'd0, exp_irq});
        end
    end

    function automatic int bit_time();
        return 16 * (int'(baud_div) + 1);
    endfunction

    // Logical frame per R3/R4/R5: start, data LSB first, parity, stops.
    function automatic logic [11:0] build(input logic [7:0] d, input bit flip_par, output int nd, output int pen);
        logic [11:0] fb;
        int ones;
        logic pb;
        nd   = 5 + int'(len_sel);
        pen  = (par_sel == 2'b01 || par_sel == 2'b10) ? 1 : 0;
        fb   = '1;
        fb[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            fb[i+1] = d[i];
            if (d[i]) ones++;
        end
        pb = (par_sel == 2'b01) ? ((ones % 2) == 0) : ((ones % 2) == 1);
        if (pen == 1) fb[nd+1] = pb ^ flip_par;
        return fb;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Transmit one frame and track the line bit by bit; optionally try a
    // second write mid-frame (R7).
    task automatic tx_frame(input logic [7:0] d, input bit extra_wr, input string req);
        logic [11:0] fb;
        int nd, pen, n, B;
        fb = build(d, 1'b0, nd, pen);
        n  = 1 + nd + pen + (stop_two ? 2 : 1);
        B  = bit_time();
        @(negedge clk);
        cur_req  = req;
        tx_data  = d;
        tx_wr    = 1'b1;
        exp_txd  = fb[0] ^ line_inv;
        exp_busy = 1'b1;
        for (int c = 1; c <= n * B; c++) begin
            @(negedge clk);
            tx_wr = extra_wr && (c == 2 * B);
            if (c == 2 * B) tx_data = ~d;
            if (c < n * B) exp_txd = fb[c / B] ^ line_inv;
            else begin
                exp_txd  = 1'b1 ^ line_inv;
                exp_busy = 1'b0;
                exp_irq  = irq_en;
            end
        end
        @(negedge clk);
        tx_wr   = 1'b0;
        exp_irq = 1'b0;
    endtask

    // Drive one frame on rxd; when expect is set, predict the result at
    // the cycle given by R9.
    task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            input bit expect_it, input string req);
        logic [11:0] fb;
        int nd, pen, n, nb, B, cc;
        logic lv;
        fb = build(d, bad_par, nd, pen);
        n  = nd + pen + 1;
        if (bad_stop) fb[n] = 1'b0;
        nb = n + 1 + (stop_two ? 1 : 0);
        B  = bit_time();
        cc = 2 + (8 + 16 * n) * (int'(baud_div) + 1);
        @(negedge clk);
        cur_req = req;
        rxd = fb[0] ^ line_inv;
        for (int c = 1; c <= nb * B + 2 * B; c++) begin
            @(negedge clk);
            lv = (c < nb * B) ? fb[c / B] : 1'b1;
            if (bad_stop && c >= n * B + B / 2 + 4) lv = 1'b1;
            rxd = lv ^ line_inv;
            if (expect_it && c == cc) begin
                exp_ovr   = exp_ovr | exp_valid;
                exp_valid = 1'b1;
                exp_data  = d & ((8'd1 << nd) - 8'd1);
                exp_perr  = bad_par;
                exp_ferr  = bad_stop;
                exp_irq   = irq_en;
            end
            if (expect_it && c == cc + 1) exp_irq = 1'b0;
        end
    endtask

    task automatic read_rx(input string req);
        @(negedge clk);
        cur_req   = req;
        rx_rd     = 1'b1;
        exp_valid = 1'b0;
        exp_ovr   = 1'b0;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog: actual hung, expected finished");
        summary();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);

        // R2, R3, R12: 8 data bits, no parity, one stop
        tx_frame(8'hA5, 1'b0, "R3");
        idle(10);
        // R4: 5 bits odd parity; upper data bits not sent
        @(negedge clk); len_sel = 2'd0; par_sel = 2'b01;
        tx_frame(8'hF3, 1'b0, "R4");
        idle(10);
        // R4, R5: 7 bits even parity, two stop bits
        @(negedge clk); len_sel = 2'd2; par_sel = 2'b10; stop_two = 1'b1;
        tx_frame(8'h5A, 1'b0, "R5");
        idle(10);
        // R12: masked interrupt; R7: a write while busy is ignored
        @(negedge clk); irq_en = 1'b0; stop_two = 1'b0; par_sel = 2'b11; len_sel = 2'd3;
        tx_frame(8'h3C, 1'b1, "R7");
        idle(10);
        @(negedge clk); irq_en = 1'b1;
        // R6: inverted line, 6 bits odd parity
        @(negedge clk); line_inv = 1'b1; len_sel = 2'd1; par_sel = 2'b01; exp_txd = 1'b0;
        idle(4);
        tx_frame(8'h2C, 1'b0, "R6");
        idle(10);
        @(negedge clk); line_inv = 1'b0; exp_txd = 1'b1;
        // R2: fastest divider
        @(negedge clk); baud_div = 16'd0; len_sel = 2'd3; par_sel = 2'b00;
        tx_frame(8'h81, 1'b0, "R2");
        idle(10);

        // Switch to receive; R7: write in receive mode has no effect
        @(negedge clk); baud_div = 16'd1; dir_tx = 1'b0;
        idle(8);
        @(negedge clk); cur_req = "R7"; tx_wr = 1'b1; tx_data = 8'hFF;
        @(negedge clk); tx_wr = 1'b0;
        idle(40);

        // R9: plain 8-bit receive, then read (R11)
        rx_frame(8'h3C, 1'b0, 1'b0, 1'b1, "R9");
        read_rx("R11");
        // R10: 7 bits even parity, good then bad parity
        @(negedge clk); len_sel = 2'd2; par_sel = 2'b10;
        rx_frame(8'h55, 1'b0, 1'b0, 1'b1, "R4");
        read_rx("R11");
        rx_frame(8'h16, 1'b1, 1'b0, 1'b1, "R10");
        read_rx("R11");
        // R10: framing error, data still delivered
        @(negedge clk); par_sel = 2'b00; len_sel = 2'd3;
        rx_frame(8'hC3, 1'b0, 1'b1, 1'b1, "R10");
        // R11: second frame without a read sets overrun and replaces data
        rx_frame(8'h9E, 1'b0, 1'b0, 1'b1, "R11");
        read_rx("R11");
        // R8: short glitch on the line is dropped
        @(negedge clk); cur_req = "R8"; rxd = 1'b0;
        idle(4);
        rxd = 1'b1;
        idle(100);
        // R6: inverted receive, 6 bits odd parity
        @(negedge clk); line_inv = 1'b1; rxd = 1'b0; len_sel = 2'd1; par_sel = 2'b01; exp_txd = 1'b0;
        idle(80);
        rx_frame(8'h2B, 1'b0, 1'b0, 1'b1, "R6");
        @(negedge clk); line_inv = 1'b0; rxd = 1'b1; exp_txd = 1'b1;
        idle(80);
        // R5: two stop bits configured, receiver checks the first
        @(negedge clk); stop_two = 1'b1; len_sel = 2'd3; par_sel = 2'b00;
        rx_frame(8'h7E, 1'b0, 1'b0, 1'b1, "R5");
        read_rx("R11");
        // R7: line activity while transmit is selected is ignored
        @(negedge clk); dir_tx = 1'b1; stop_two = 1'b0;
        rx_frame(8'h11, 1'b0, 1'b0, 1'b0, "R7");
        idle(20);

        summary();
    end
endmodule